// File: doc/BRIEF.md
# Indexed Register Stack Engine

This block keeps a data stack for a stack-oriented virtual machine inside the upper part of an ordinary register file, not in a dedicated LIFO memory. Four index registers point at the top entry and at the three entries below it. Every operation reads its operands through those indexes and writes its result back into the register file. It then sets the new top index and derives the three lower indexes from it at fixed offsets.

A host presents one operation at a time with `op_valid` while `ready` is high. The engine checks the top index against the lower bound of the window before it commits anything. An operation that would take more entries than the stack holds sets `underflow`. An operation that would grow a full stack sets `overflow`. In both cases the stack, its indexes and the visible top value stay as they were. The value of the top entry, the depth and all four indexes are always visible at the ports.

Top module: `irs_engine`

## Requirements
- R1: The stack occupies registers 32 through 127, up to 96 entries. After reset it is empty: `depth` is 0 and `tos_idx` is 31. After every operation `depth` equals `tos_idx` minus 31.
- R2: After reset `lvl1_idx`, `lvl2_idx` and `lvl3_idx` read 30, 29 and 28, `top_data` reads 0, both flags are low and `ready` is high.
- R3: After every completed operation, `lvl1_idx`, `lvl2_idx` and `lvl3_idx` equal `tos_idx` minus 1, 2 and 3.
- R4: ADD (code 3) writes the sum of the top and level-1 entries, modulo 2^32, into the level-1 slot. That slot becomes the new top, so depth drops by one.
- R5: Each operation has a minimum depth: 1 for DROP and DUP, 2 for ADD, SWAP and OVER. Below that minimum, `underflow` goes high and the stack, indexes and `top_data` are unchanged.
- R6: An accepted ADD or any other non-SWAP operation has `ready` high again two rising edges after the accepting edge, with its results visible.
- R7: Registers 0 and 1 are never written, and no index ever points below register 2.
- R8: PUSH, DUP or OVER on a stack holding 96 entries sets `overflow` and leaves the stack, indexes and `top_data` unchanged.
- R9: DUP (code 4) copies the top entry to the slot above it and makes that slot the top.
- R10: SWAP (code 5) exchanges the top and level-1 entries and needs three rising edges, counting the accepting edge, before `ready` is high again.
- R11: OVER (code 6) copies the level-1 entry to the slot above the top and makes that slot the top.
- R12: PUSH (code 1) places `push_data` on top. DROP (code 2) removes the top entry, and `top_data` then shows the new top, or 0 when the stack is empty.
- R13: Each accepted operation, including NOP (code 0 or 7), replaces both flags with its own result, so a successful operation clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present; accepted when `ready` is high |
| op_code | input | 3 | 0 NOP, 1 PUSH, 2 DROP, 3 ADD, 4 DUP, 5 SWAP, 6 OVER, 7 NOP |
| push_data | input | DATA_W | Value for PUSH |
| ready | output | 1 | Engine idle and able to accept |
| top_data | output | DATA_W | Value of the top entry, 0 when empty |
| depth | output | DEP_W | Number of entries held |
| tos_idx | output | AW | Register index of the top entry |
| lvl1_idx | output | AW | Index of the entry one below the top |
| lvl2_idx | output | AW | Index of the entry two below the top |
| lvl3_idx | output | AW | Index of the entry three below the top |
| underflow | output | 1 | Last operation was refused for lack of entries |
| overflow | output | 1 | Last operation was refused because the stack was full |

## Verification
The hardest state to reach from the ports is a completely full window. Only there can the overflow path for PUSH, DUP and OVER be checked, together with the top index at its upper limit. The stimulus gets there with 96 back-to-back pushes, checking each one, and then tries all three growing operations. It clears the flag with a DROP and drains the whole stack down to underflow at the lower bound. A software stack model predicts every value, index and flag along the way. A shorter vector table covers mixed sequences, underflow from depths zero and one, and 32-bit wraparound in ADD.

// File: rtl/irs_pkg.sv
package irs_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_DROP = 3'd2,
    OP_ADD  = 3'd3,
    OP_DUP  = 3'd4,
    OP_SWAP = 3'd5,
    OP_OVER = 3'd6,
    OP_RSVD = 3'd7
  } irs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } irs_state_e;
endpackage

// File: rtl/irs_regfile.sv
// Register file slice holding the stack window: two synchronous read
// ports and one write port, written in a RAM-inferable form.
module irs_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 128,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     ra_addr,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      ra_data <= mem[ra_addr];
      rb_data <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/irs_decode.sv
// Decides, before anything is committed, whether an operation lacks
// operands or would grow a full stack.
module irs_decode
  import irs_pkg::*;
#(
  parameter int NREG = 128,
  parameter int BASE = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  irs_op_e       op,
  input  logic [AW-1:0] tos,
  output logic          uf,
  output logic          ovf
);
  localparam logic [AW:0]   FLOOR = (AW+1)'(BASE - 1);
  localparam logic [AW-1:0] CEIL  = AW'(NREG - 1);

  logic [1:0] need;
  logic       grows;

  always_comb begin
    need  = 2'd0;
    grows = 1'b0;
    unique case (op)
      OP_PUSH: grows = 1'b1;
      OP_DROP: need  = 2'd1;
      OP_DUP:  begin need = 2'd1; grows = 1'b1; end
      OP_ADD:  need  = 2'd2;
      OP_SWAP: need  = 2'd2;
      OP_OVER: begin need = 2'd2; grows = 1'b1; end
      default: ;
    endcase
  end

  // Top index compared with the lower bound plus the operand need.
  assign uf  = ({1'b0, tos} < (FLOOR + {{(AW-1){1'b0}}, need}));
  assign ovf = grows && !uf && (tos == CEIL);
endmodule

// File: rtl/irs_index.sv
// Top index plus the lower-level indexes, each held in its own register
// and reloaded at a fixed offset whenever the top moves.
module irs_index #(
  parameter int NREG = 128,
  parameter int BASE = 32,
  parameter int NLVL = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [AW-1:0]            new_tos,
  output logic [AW-1:0]            tos,
  output logic [NLVL-1:0][AW-1:0]  lvl
);
  logic [AW-1:0] tos_q;
  logic [NLVL-1:0][AW-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst)      tos_q <= AW'(BASE - 1);
    else if (upd) tos_q <= new_tos;
  end

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)      lvl_q[k] <= AW'(BASE - 2 - k);
      else if (upd) lvl_q[k] <= new_tos - AW'(k + 1);
    end

    p_lvl_offset_r3: assert property (@(posedge clk) disable iff (rst)
      lvl_q[k] == tos_q - AW'(k + 1));
  end

  p_window_r1: assert property (@(posedge clk) disable iff (rst)
    (tos_q >= AW'(BASE - 1)) && (tos_q <= AW'(NREG - 1)));

  assign tos = tos_q;
  assign lvl = lvl_q;
endmodule

// File: rtl/irs_engine.sv
module irs_engine
  import irs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 128,
  parameter int BASE   = 32,
  localparam int AW    = $clog2(NREG),
  localparam int CAP   = NREG - BASE,
  localparam int DEP_W = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] push_data,
  output logic              ready,
  output logic [DATA_W-1:0] top_data,
  output logic [DEP_W-1:0]  depth,
  output logic [AW-1:0]     tos_idx,
  output logic [AW-1:0]     lvl1_idx,
  output logic [AW-1:0]     lvl2_idx,
  output logic [AW-1:0]     lvl3_idx,
  output logic              underflow,
  output logic              overflow
);
  localparam int NLVL = 3;

  irs_state_e          state_q;
  irs_op_e             op_in, op_q;
  logic [DATA_W-1:0]   push_q, top_q;
  logic                uf_in, ovf_in, uf_q, ovf_q, uf_flag, ovf_flag;
  logic [DEP_W-1:0]    depth_q;
  logic                accept;

  logic [AW-1:0]             tos;
  logic [NLVL-1:0][AW-1:0]   lvl;
  logic                      upd;
  logic [AW-1:0]             nt;

  logic              we;
  logic [AW-1:0]     wa;
  logic [DATA_W-1:0] wd, ra, rb, sum;
  logic              commit;

  assign op_in  = irs_op_e'(op_code);
  assign accept = op_valid && (state_q == ST_IDLE);
  assign sum    = ra + rb;
  assign commit = (state_q == ST_RUN) && !uf_q && !ovf_q;

  irs_decode #(.NREG(NREG), .BASE(BASE)) u_decode (
    .op (op_in), .tos(tos), .uf(uf_in), .ovf(ovf_in)
  );

  irs_index #(.NREG(NREG), .BASE(BASE), .NLVL(NLVL)) u_index (
    .clk(clk), .rst(rst), .upd(upd), .new_tos(nt), .tos(tos), .lvl(lvl)
  );

  irs_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rd_en(accept), .ra_addr(tos), .rb_addr(lvl[0]),
    .ra_data(ra), .rb_data(rb), .we(we), .wa(wa), .wd(wd)
  );

  // Write port and index update for the committing cycle.
  always_comb begin
    we  = 1'b0;
    wa  = tos;
    wd  = ra;
    upd = 1'b0;
    nt  = tos;
    if (commit) begin
      unique case (op_q)
        OP_PUSH: begin we = 1'b1; wa = tos + AW'(1); wd = push_q; upd = 1'b1; nt = tos + AW'(1); end
        OP_DROP: begin upd = 1'b1; nt = lvl[0]; end
        OP_ADD:  begin we = 1'b1; wa = lvl[0]; wd = sum; upd = 1'b1; nt = lvl[0]; end
        OP_DUP:  begin we = 1'b1; wa = tos + AW'(1); wd = ra; upd = 1'b1; nt = tos + AW'(1); end
        OP_OVER: begin we = 1'b1; wa = tos + AW'(1); wd = rb; upd = 1'b1; nt = tos + AW'(1); end
        OP_SWAP: begin we = 1'b1; wa = tos; wd = rb; end
        default: ;
      endcase
    end else if (state_q == ST_FIX) begin
      we = 1'b1;
      wa = lvl[0];
      wd = ra;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NOP;
      push_q   <= '0;
      uf_q     <= 1'b0;
      ovf_q    <= 1'b0;
      top_q    <= '0;
      uf_flag  <= 1'b0;
      ovf_flag <= 1'b0;
      depth_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          op_q    <= op_in;
          push_q  <= push_data;
          uf_q    <= uf_in;
          ovf_q   <= ovf_in;
        end
        ST_RUN: begin
          uf_flag  <= uf_q;
          ovf_flag <= ovf_q;
          state_q  <= (commit && op_q == OP_SWAP) ? ST_FIX : ST_IDLE;
          if (commit) begin
            unique case (op_q)
              OP_PUSH: top_q <= push_q;
              OP_DROP: top_q <= (tos == AW'(BASE)) ? '0 : rb;
              OP_ADD:  top_q <= sum;
              OP_DUP:  top_q <= ra;
              OP_OVER: top_q <= rb;
              OP_SWAP: top_q <= rb;
              default: ;
            endcase
          end
          if (upd) depth_q <= DEP_W'(nt - AW'(BASE - 1));
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state_q == ST_IDLE);
  assign top_data  = top_q;
  assign depth     = depth_q;
  assign tos_idx   = tos;
  assign lvl1_idx  = lvl[0];
  assign lvl2_idx  = lvl[1];
  assign lvl3_idx  = lvl[2];
  assign underflow = uf_flag;
  assign overflow  = ovf_flag;

  p_no_low_write_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (wa >= AW'(BASE)));

  p_add_two_cycles_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == OP_ADD) |-> ##2 ready);

  p_uf_keeps_stack_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && uf_q) |=> (tos == $past(tos)) && $stable(top_q) && uf_flag);

  p_ovf_keeps_stack_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && ovf_q) |=> (tos == $past(tos)) && $stable(top_q) && ovf_flag);

  p_flags_apart_r13: assert property (@(posedge clk) disable iff (rst)
    !(uf_flag && ovf_flag));
endmodule

// File: tb/test_irs_engine.sv
`timescale 1ns/1ps
module test_irs_engine;
  localparam int DW   = 32;
  localparam int NREG = 128;
  localparam int BASE = 32;
  localparam int AW   = 7;
  localparam int CAP  = 96;
  localparam int DEPW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic [DW-1:0] push_data = '0;
  logic          ready;
  logic [DW-1:0] top_data;
  logic [DEPW-1:0] depth;
  logic [AW-1:0] tos_idx, lvl1_idx, lvl2_idx, lvl3_idx;
  logic          underflow, overflow;

  always #2.5 clk = ~clk;

  irs_engine #(.DATA_W(DW), .NREG(NREG), .BASE(BASE)) i_irs_engine (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .push_data(push_data), .ready(ready), .top_data(top_data),
    .depth(depth), .tos_idx(tos_idx), .lvl1_idx(lvl1_idx),
    .lvl2_idx(lvl2_idx), .lvl3_idx(lvl3_idx),
    .underflow(underflow), .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_stk [CAP];
  int m_dep = 0;

  // op(3) and data(32)
  localparam int NV = 20;
  localparam logic [34:0] VEC [NV] = '{
    {3'd1, 32'd5},  {3'd1, 32'd7},  {3'd3, 32'd0},  {3'd4, 32'd0},
    {3'd6, 32'd0},  {3'd1, 32'd3},  {3'd5, 32'd0},  {3'd3, 32'd0},
    {3'd2, 32'd0},  {3'd3, 32'd0},  {3'd2, 32'd0},  {3'd2, 32'd0},
    {3'd4, 32'd0},  {3'd1, 32'd9},  {3'd3, 32'd0},  {3'd5, 32'd0},
    {3'd6, 32'd0},  {3'd0, 32'd0},  {3'd1, 32'hFFFF_FFFF}, {3'd3, 32'd0}
  };

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1, 3'd2: return "R12";
      3'd3:       return "R4";
      3'd4:       return "R9";
      3'd5:       return "R10";
      3'd6:       return "R11";
      default:    return "R13";
    endcase
  endfunction

  task automatic check_state(input string t);
    logic [DW-1:0] etop;
    etop = (m_dep > 0) ? m_stk[m_dep-1] : '0;
    chk(t, "top_data", top_data, etop);
    chk("R1", "depth", depth, m_dep);
    chk("R1", "tos_idx", tos_idx, BASE - 1 + m_dep);
    chk("R3", "lvl1_idx", lvl1_idx, BASE - 2 + m_dep);
    chk("R3", "lvl2_idx", lvl2_idx, BASE - 3 + m_dep);
    chk("R3", "lvl3_idx", lvl3_idx, BASE - 4 + m_dep);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_dep = 0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [DW-1:0] d);
    int need, cyc, ecyc;
    bit grows, e_uf, e_ovf;
    logic [DW-1:0] tmp;
    string t;
    t = op_tag(op);
    need = 0; grows = 0;
    case (op)
      3'd1: grows = 1;
      3'd2: need = 1;
      3'd3: need = 2;
      3'd4: begin need = 1; grows = 1; end
      3'd5: need = 2;
      3'd6: begin need = 2; grows = 1; end
      default: ;
    endcase
    e_uf  = (m_dep < need);
    e_ovf = !e_uf && grows && (m_dep == CAP);
    ecyc  = (op == 3'd5 && !e_uf) ? 3 : 2;

    @(negedge clk);
    op_valid = 1'b1; op_code = op; push_data = d;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    op_valid = 1'b0;
    while (!ready && cyc < 10) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end

    if (!e_uf && !e_ovf) begin
      case (op)
        3'd1: begin m_stk[m_dep] = d; m_dep++; end
        3'd2: m_dep--;
        3'd3: begin m_stk[m_dep-2] = m_stk[m_dep-2] + m_stk[m_dep-1]; m_dep--; end
        3'd4: begin m_stk[m_dep] = m_stk[m_dep-1]; m_dep++; end
        3'd6: begin m_stk[m_dep] = m_stk[m_dep-2]; m_dep++; end
        3'd5: begin tmp = m_stk[m_dep-1]; m_stk[m_dep-1] = m_stk[m_dep-2]; m_stk[m_dep-2] = tmp; end
        default: ;
      endcase
    end

    check_state(t);
    chk(e_uf ? "R5" : "R13", "underflow", underflow, e_uf);
    chk(e_ovf ? "R8" : "R13", "overflow", overflow, e_ovf);
    chk(op == 3'd3 ? "R6" : (op == 3'd5 ? "R10" : t), "cycles", cyc, ecyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: reset state
    chk("R2", "ready", ready, 1);
    chk("R2", "underflow", underflow, 0);
    chk("R2", "overflow", overflow, 0);
    check_state("R2");
    chk("R7", "lvl3 floor", lvl3_idx >= 2, 1);

    // Table walk
    for (int i = 0; i < NV; i++) run_op(VEC[i][34:32], VEC[i][31:0]);

    // Underflow at the empty bound keeps indexes off registers 0 and 1
    do_reset();
    run_op(3'd2, '0);
    run_op(3'd3, '0);
    chk("R7", "lvl3 floor after underflow", lvl3_idx >= 2, 1);

    // Fill the whole window
    for (int i = 0; i < CAP; i++) run_op(3'd1, DW'(i * 3 + 1));
    chk("R1", "full depth", depth, CAP);
    run_op(3'd1, 32'hDEAD);
    run_op(3'd4, '0);
    run_op(3'd6, '0);
    run_op(3'd2, '0);
    chk("R13", "overflow cleared", overflow, 0);
    run_op(3'd5, '0);
    run_op(3'd6, '0);
    run_op(3'd1, 32'h55);
    run_op(3'd4, '0);
    // Drain to underflow
    for (int i = 0; i < CAP; i++) run_op(3'd2, '0);
    run_op(3'd2, '0);
    chk("R5", "drained depth", depth, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule